// File: doc/BRIEF.md
# Dual-rank bus register with serial shifter

The block holds two registers of equal width. The first is a holding register on the bus side. The second is a serial shift register beside it. Both update on the rising clock edge. Five active-low controls select the work done at each edge. The holding register can take the pin data, take the pin data ORed with the shift register, or take the shift register contents. The shift register can take the holding register contents or shift one place. Both registers can also be cleared together. Several of these operations can take place in the same edge. In that case each register reads the values that the other held before the edge.

The bidirectional bus is split into three signals. `io_in` carries the pin data into the block, `io_out` always shows the holding register, and `io_oe` tells the pad when to drive. The pad enable only decides who drives the bus. It never blocks a register operation.

Wider words are built by chaining blocks. The serial output of one block feeds the serial input of the next.

Top module: `dual_rank_shifter`

## Requirements
- R1: When reset is asserted, both registers become zero, so `io_out` and `sout` read 0.
- R2: `io_oe` is 1 only when `out_n` is 0 and `in_n` is 1. When both are 0 the pins act as inputs and `io_oe` is 0. `io_out` always shows the holding register.
- R3: With `in_n`=0 and `up_n`=1 on an edge, the holding register takes `io_in`, whatever the level of `out_n`.
- R4: With `up_n`=0, `in_n`=1 and `down_n`=1 on an edge, the holding register takes the shift register value from before the edge.
- R5: With `in_n`=0, `up_n`=0 and `down_n`=1 on an edge, the holding register takes `io_in` bitwise ORed with the shift register value from before the edge.
- R6: With `down_n`=0 and `up_n`=1 on an edge, the shift register takes the holding register value from before the edge. A shift requested in the same edge is ignored.
- R7: With `shift_n`=0, `down_n`=1 and no clear, the shift register moves one place toward its top bit on the edge, and `sin` enters bit 0. `sout` always shows the top bit.
- R8: With `up_n`=0, `down_n`=0 and `in_n`=1 on an edge, both registers become zero, whatever `shift_n` is.
- R9: With `up_n`=0, `down_n`=0 and `in_n`=0 on an edge, the holding register takes `io_in` and the shift register becomes zero.
- R10: When functions on both registers fall in one edge, each register reads the other's value from before the edge. This covers up plus shift, load plus down, and load plus shift.
- R11: With `in_n`, `up_n`, `down_n` and `shift_n` all 1, neither register changes, whatever `io_in`, `sin` or `out_n` are.
- R12: When blocks are chained serial output to serial input, a shift moves the top bit of one block into bit 0 of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| out_n | input | 1 | Pin drive request, active low |
| in_n | input | 1 | Pin capture into holding register, active low |
| up_n | input | 1 | Shift register to holding register copy, active low |
| down_n | input | 1 | Holding register to shift register copy, active low |
| shift_n | input | 1 | Serial shift of the shift register, active low |
| sin | input | 1 | Serial data into bit 0 |
| io_in | input | WIDTH | Data arriving at the pins |
| io_out | output | WIDTH | Holding register contents toward the pins |
| io_oe | output | 1 | Pad drive enable |
| sout | output | 1 | Top bit of the shift register |

## Verification
The hardest case is an edge that carries a transfer up and a serial shift at once. The bench first loads a known, asymmetric pattern into the shift register. It then asserts `up_n` and `shift_n` together. It expects `io_out` to show the pattern as it was before the shift. It expects the shifted value only on a later transfer up. The bench also pairs a pin load with a transfer down in one edge. It checks that the shift register receives the old holding value, not the new pin data.

// File: rtl/dual_rank_shifter.sv
module dual_rank_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_n,
  input  logic             in_n,
  input  logic             up_n,
  input  logic             down_n,
  input  logic             shift_n,
  input  logic             sin,
  input  logic [WIDTH-1:0] io_in,
  output logic [WIDTH-1:0] io_out,
  output logic             io_oe,
  output logic             sout
);

  logic [WIDTH-1:0] a_q, b_q, a_d, b_d;
  logic             clr;

  assign clr    = !up_n && !down_n;
  assign io_oe  = !out_n && in_n;
  assign io_out = a_q;
  assign sout   = b_q[WIDTH-1];

  always_comb begin
    a_d = a_q;
    if (clr)
      a_d = in_n ? '0 : io_in;
    else if (!in_n)
      a_d = up_n ? io_in : (io_in | b_q);
    else if (!up_n)
      a_d = b_q;
  end

  always_comb begin
    b_d = b_q;
    if (clr)
      b_d = '0;
    else if (!down_n)
      b_d = a_q;
    else if (!shift_n)
      b_d = {b_q[WIDTH-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // R2
  pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_n |-> !io_oe);

  // R3
  pin_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_n && up_n) |=> (io_out == $past(io_in)));

  // R4
  up_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_n && !up_n && down_n) |=> (a_q == $past(b_q)));

  // R6
  down_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_n && !down_n) |=> (b_q == $past(a_q)));

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (down_n && !shift_n && !clr) |=> (sout == $past(b_q[WIDTH-2])));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n && !down_n) |=> (b_q == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_n && up_n) |=> $stable(io_out));

endmodule

// File: tb/dual_rank_shifter_test.sv
`timescale 1ns/1ps
module dual_rank_shifter_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       out_n = 1, in_n = 1, up_n = 1, down_n = 1, shift_n = 1;
  logic       sin = 0;
  logic [7:0] io_in = 0;
  logic [7:0] io_out, link_out;
  logic       io_oe, link_oe, sout, link_sout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_rank_shifter #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .out_n(out_n), .in_n(in_n), .up_n(up_n),
    .down_n(down_n), .shift_n(shift_n), .sin(sin), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .sout(sout));

  dual_rank_shifter #(.WIDTH(8)) link (
    .clk(clk), .rst_n(rst_n), .out_n(out_n), .in_n(in_n), .up_n(up_n),
    .down_n(down_n), .shift_n(shift_n), .sin(sout), .io_in(io_in),
    .io_out(link_out), .io_oe(link_oe), .sout(link_sout));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // c = {out_n, in_n, up_n, down_n, shift_n}
  task automatic step(input logic [4:0] c, input logic [7:0] d, input logic s);
    {out_n, in_n, up_n, down_n, shift_n} = c;
    io_in = d;
    sin = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_b(input string tag, input logic [7:0] exp);
    step(5'b11011, 8'h00, 0);
    chk(tag, io_out, exp);
  endtask

  task automatic t_reset;
    chk("R1 io_out", io_out, 8'h00);
    chk("R1 sout", {7'b0, sout}, 8'h00);
  endtask

  task automatic t_pins;
    {out_n, in_n} = 2'b01; #1;
    chk("R2 drive", {7'b0, io_oe}, 8'h01);
    {out_n, in_n} = 2'b00; #1;
    chk("R2 input wins", {7'b0, io_oe}, 8'h00);
    {out_n, in_n} = 2'b11; #1;
    chk("R2 idle", {7'b0, io_oe}, 8'h00);
  endtask

  task automatic t_load_down_up;
    step(5'b00111, 8'hA5, 0);
    chk("R3 load", io_out, 8'hA5);
    step(5'b11100, 8'h00, 1);
    step(5'b10111, 8'h3C, 0);
    chk("R3 load", io_out, 8'h3C);
    step(5'b11011, 8'h00, 0);
    chk("R6 down ignores shift / R4 up", io_out, 8'hA5);
  endtask

  task automatic t_or;
    step(5'b10011, 8'h0A, 0);
    chk("R5 data or", io_out, 8'hAF);
  endtask

  task automatic t_shift;
    chk("R7 sout top", {7'b0, sout}, 8'h01);
    step(5'b11110, 8'h00, 0);
    chk("R7 sout after shift", {7'b0, sout}, 8'h00);
    step(5'b11110, 8'h00, 1);
    chk("R7 sout", {7'b0, sout}, 8'h01);
    step(5'b11010, 8'h00, 0);
    chk("R10 up with shift", io_out, 8'h95);
    read_b("R7 shifted value", 8'h2A);
  endtask

  task automatic t_load_down;
    step(5'b10101, 8'h77, 0);
    chk("R10 load with down A", io_out, 8'h77);
    read_b("R10 load with down B", 8'h2A);
    step(5'b10110, 8'h11, 1);
    chk("R10 load with shift A", io_out, 8'h11);
    read_b("R10 load with shift B", 8'h55);
  endtask

  task automatic t_clear;
    step(5'b11000, 8'hFF, 1);
    chk("R8 clear A", io_out, 8'h00);
    read_b("R8 clear B", 8'h00);
    step(5'b10111, 8'hF0, 0);
    step(5'b11101, 8'h00, 0);
    step(5'b10001, 8'h5A, 0);
    chk("R9 load and clear A", io_out, 8'h5A);
    chk("R9 sout", {7'b0, sout}, 8'h00);
    read_b("R9 B cleared", 8'h00);
  endtask

  task automatic t_hold;
    step(5'b10111, 8'hC6, 0);
    step(5'b11101, 8'h00, 0);
    step(5'b01111, 8'hFF, 1);
    step(5'b11111, 8'h0F, 1);
    chk("R11 hold A", io_out, 8'hC6);
    chk("R11 hold sout", {7'b0, sout}, 8'h01);
    step(5'b00111, 8'h3E, 0);
    chk("R3 load while driving", io_out, 8'h3E);
    step(5'b01011, 8'h00, 0);
    chk("R11 B held", io_out, 8'hC6);
  endtask

  task automatic t_cascade;
    step(5'b11000, 8'h00, 0);
    step(5'b10111, 8'hC3, 0);
    step(5'b11101, 8'h00, 0);
    for (int i = 0; i < 8; i++) step(5'b11110, 8'h00, 0);
    step(5'b11011, 8'h00, 0);
    chk("R12 first stage", io_out, 8'h00);
    chk("R12 second stage", link_out, 8'hC3);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_pins();
    t_load_down_up();
    t_or();
    t_shift();
    t_load_down();
    t_clear();
    t_hold();
    t_cascade();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule